// File: doc/BRIEF.md
# Transmit Buffer Descriptor Sequencer

This block feeds a byte-serial framer from a circular table of transmit buffer descriptors. The descriptor table and the byte buffer storage both sit inside the block. Each has a simple register-style host port for writes, and the descriptor table can also be read back. Once enabled, the sequencer watches the descriptor at its current table position until software marks it ready. It then copies that descriptor and streams the buffer's bytes to the framer with a valid/ready handshake.

When a buffer ends, the sequencer returns the descriptor to software by clearing its ready flag. If the buffer closes a frame, the sequencer first waits for the framer to report that the closing flag has gone out, then also sets a completion status flag. A buffer in the middle of a frame gets only the ready clear, and the frame carries on from the next descriptor. Each descriptor has its own interrupt flag, so software can choose to be notified per buffer, per frame or after a group of frames.

A stop request abandons the buffer in flight and leaves the descriptor owned by hardware. A restart request then sends that descriptor again. Dropping the enable returns the sequencer to the head of the table.

Top module: `tx_bd_seq`

## Requirements
- R1: After reset the block drives no byte and no interrupt. With enable high it polls table entry 0 and sends nothing while that entry's ready flag (bit 24) is clear.
- R2: A ready descriptor with length L (bits 15:0) and base B (bits 23:16) sends buffer bytes B, B+1, ..., B+L-1, with addresses wrapping modulo the buffer depth, one per accepted handshake. While the framer stalls, the byte and its valid are held.
- R3: For a descriptor whose last flag (bit 25) is set, its final byte carries the end-of-frame mark. After a closing-flag report from the framer, the ready flag is cleared and the sent status flag (bit 28) is set.
- R4: For a descriptor whose last flag is clear, no byte is marked end-of-frame, no framer report is awaited, only the ready flag is cleared, and the sent flag keeps its prior value.
- R5: Every completed descriptor whose interrupt flag (bit 26) is set gives exactly one single-cycle interrupt pulse. Descriptors without the flag give none.
- R6: After a completion the sequencer moves to the next entry. It moves to entry 0 instead when the descriptor's wrap flag (bit 27) is set or when the entry is the last in the table.
- R7: A stop request during streaming or while waiting for the framer report ends byte output at once and pulses the abort output for one cycle. The current descriptor keeps its ready flag, and its sent flag is not set.
- R8: After a stop, a restart request resumes polling at the same entry, and its buffer is sent again from its first byte.
- R9: A zero-length descriptor completes without sending a byte and without waiting for a framer report. It still clears ready, sets sent if its last flag is set, and raises its interrupt if the interrupt flag is set.
- R10: With enable low no byte is offered, and the next enable starts again at entry 0.
- R11: The host read port returns each descriptor as last written, with the sequencer's flag updates applied and its length and base unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Sequencer enable; low returns to entry 0 |
| stop_req | input | 1 | Abort the buffer in flight and halt |
| restart_req | input | 1 | Leave the halted state and poll again |
| bd_we | input | 1 | Host descriptor write strobe |
| bd_addr | input | IDX_W | Host descriptor index for read and write |
| bd_wdata | input | DESC_W | Descriptor word to write |
| bd_rdata | output | DESC_W | Descriptor word at bd_addr |
| buf_we | input | 1 | Host buffer byte write strobe |
| buf_addr | input | BUF_AW | Host buffer byte address |
| buf_wdata | input | 8 | Buffer byte to write |
| tx_valid | output | 1 | Byte offered to the framer |
| tx_ready | input | 1 | Framer accepts the offered byte |
| tx_data | output | 8 | Offered byte |
| tx_last | output | 1 | Offered byte ends the frame |
| fr_sent | input | 1 | Framer pulse: closing flag transmitted |
| tx_abort | output | 1 | One-cycle pulse when a stop cuts a frame |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The assertions assume that software leaves alone every descriptor whose ready flag is set, and every buffer byte that a ready descriptor covers, until the sequencer hands that descriptor back. They also assume that stop and restart arrive as isolated pulses. The stimulus keeps to these rules in three ways. It writes whole chains while the sequencer is disabled. It only rewrites entries it has already seen come back with ready clear. It leaves the buffer contents fixed once the first chain starts. Framer stalls are random and the closing-flag report follows a fixed delay after each end-of-frame byte, so the hold and wait paths are both exercised within these assumptions.

// File: rtl/tx_bd_pkg.sv
package tx_bd_pkg;
   // Flag positions above the length and base fields of a descriptor word.
   localparam int FL_RDY  = 0;
   localparam int FL_LAST = 1;
   localparam int FL_INTR = 2;
   localparam int FL_WRAP = 3;
   localparam int FL_SENT = 4;
   localparam int FL_NUM  = 5;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_POLL,
      ST_STREAM,
      ST_FLAG,
      ST_WB,
      ST_HALT
   } seq_state_e;
endpackage

// File: rtl/tx_bd_table.sv
module tx_bd_table #(
   parameter int NUM_BD   = 8,
   parameter int IDX_W    = 3,
   parameter int DESC_W   = 29,
   parameter int FLAG_LSB = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [IDX_W-1:0]  host_idx,
   input  logic [DESC_W-1:0] host_wdata,
   output logic [DESC_W-1:0] host_rdata,
   input  logic [IDX_W-1:0]  seq_idx,
   output logic [DESC_W-1:0] seq_rdata,
   input  logic              wb_en,
   input  logic [IDX_W-1:0]  wb_idx,
   input  logic              wb_sent,
   output logic [NUM_BD-1:0] rdy_vec
);
   import tx_bd_pkg::*;

   logic [DESC_W-1:0] ent [NUM_BD];

   for (genvar g = 0; g < NUM_BD; g++) begin : g_ent
      localparam logic [IDX_W-1:0] SLOT = IDX_W'(g);
      // Sequencer write-back wins over a host write to the same slot.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent[g] <= '0;
         end else if (wb_en && wb_idx == SLOT) begin
            ent[g][FLAG_LSB+FL_RDY] <= 1'b0;
            if (wb_sent) ent[g][FLAG_LSB+FL_SENT] <= 1'b1;
         end else if (host_we && host_idx == SLOT) begin
            ent[g] <= host_wdata;
         end
      end
      assign rdy_vec[g] = ent[g][FLAG_LSB+FL_RDY];
   end

   assign host_rdata = ent[host_idx];
   assign seq_rdata  = ent[seq_idx];

   // R3
   wb_clears_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |=> !rdy_vec[$past(wb_idx)]);
endmodule

// File: rtl/tx_buf_mem.sv
module tx_buf_mem #(
   parameter int DEPTH = 256,
   parameter int AW    = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/tx_bd_fsm.sv
module tx_bd_fsm #(
   parameter int NUM_BD   = 8,
   parameter int IDX_W    = 3,
   parameter int LEN_W    = 16,
   parameter int BUF_AW   = 8,
   parameter int DESC_W   = 29,
   parameter int FLAG_LSB = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              stop_req,
   input  logic              restart_req,
   input  logic [DESC_W-1:0] desc,
   input  logic              tx_ready,
   input  logic              fr_sent,
   output logic [IDX_W-1:0]  cur_idx,
   output logic [BUF_AW-1:0] buf_raddr,
   output logic              tx_valid,
   output logic              tx_last,
   output logic              tx_abort,
   output logic              irq,
   output logic              wb_en,
   output logic [IDX_W-1:0]  wb_idx,
   output logic              wb_sent
);
   import tx_bd_pkg::*;

   seq_state_e        state;
   logic [IDX_W-1:0]  idx, idx_inc, nxt_idx;
   logic [LEN_W-1:0]  cnt, s_len;
   logic [BUF_AW-1:0] s_base;
   logic              s_last, s_intr, s_wrap, abort_q;
   logic              at_end;

   wire [LEN_W-1:0]  d_len  = desc[LEN_W-1:0];
   wire [BUF_AW-1:0] d_base = desc[LEN_W +: BUF_AW];
   wire              d_rdy  = desc[FLAG_LSB+FL_RDY];

   // Table size picks the increment: free rollover or an explicit end compare.
   if ((NUM_BD & (NUM_BD - 1)) == 0) begin : g_pow2
      assign idx_inc = idx + IDX_W'(1);
   end else begin : g_cmp
      assign idx_inc = (idx == IDX_W'(NUM_BD - 1)) ? '0 : idx + IDX_W'(1);
   end
   assign nxt_idx = s_wrap ? '0 : idx_inc;
   assign at_end  = (cnt == s_len - LEN_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         idx     <= '0;
         cnt     <= '0;
         s_len   <= '0;
         s_base  <= '0;
         s_last  <= 1'b0;
         s_intr  <= 1'b0;
         s_wrap  <= 1'b0;
         abort_q <= 1'b0;
      end else begin
         abort_q <= 1'b0;
         if (!en) begin
            state <= ST_IDLE;
            idx   <= '0;
         end else begin
            unique case (state)
               ST_IDLE: state <= ST_POLL;
               ST_POLL: begin
                  if (stop_req) begin
                     state <= ST_HALT;
                  end else if (d_rdy) begin
                     s_len  <= d_len;
                     s_base <= d_base;
                     s_last <= desc[FLAG_LSB+FL_LAST];
                     s_intr <= desc[FLAG_LSB+FL_INTR];
                     s_wrap <= desc[FLAG_LSB+FL_WRAP];
                     cnt    <= '0;
                     state  <= (d_len == '0) ? ST_WB : ST_STREAM;
                  end
               end
               ST_STREAM: begin
                  if (stop_req) begin
                     state   <= ST_HALT;
                     abort_q <= 1'b1;
                  end else if (tx_ready) begin
                     if (at_end) state <= s_last ? ST_FLAG : ST_WB;
                     else        cnt   <= cnt + LEN_W'(1);
                  end
               end
               ST_FLAG: begin
                  if (stop_req) begin
                     state   <= ST_HALT;
                     abort_q <= 1'b1;
                  end else if (fr_sent) begin
                     state <= ST_WB;
                  end
               end
               ST_WB: begin
                  idx   <= nxt_idx;
                  state <= ST_POLL;
               end
               ST_HALT: if (restart_req) state <= ST_POLL;
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign tx_valid  = (state == ST_STREAM);
   assign tx_last   = tx_valid && s_last && at_end;
   assign wb_en     = (state == ST_WB);
   assign wb_idx    = idx;
   assign wb_sent   = s_last;
   assign irq       = wb_en && s_intr;
   assign tx_abort  = abort_q;
   assign cur_idx   = idx;
   assign buf_raddr = s_base + cnt[BUF_AW-1:0];

   // R7
   abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_abort |-> !tx_valid);
   // R10
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!tx_valid && !irq));
   // R9
   zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_POLL && en && !stop_req && d_rdy && d_len == '0) |=> wb_en);
endmodule

// File: rtl/tx_bd_seq.sv
module tx_bd_seq #(
   parameter  int NUM_BD    = 8,
   parameter  int LEN_W     = 16,
   parameter  int BUF_DEPTH = 256,
   localparam int IDX_W     = $clog2(NUM_BD),
   localparam int BUF_AW    = $clog2(BUF_DEPTH),
   localparam int FLAG_LSB  = LEN_W + BUF_AW,
   localparam int DESC_W    = FLAG_LSB + tx_bd_pkg::FL_NUM
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              stop_req,
   input  logic              restart_req,
   input  logic              bd_we,
   input  logic [IDX_W-1:0]  bd_addr,
   input  logic [DESC_W-1:0] bd_wdata,
   output logic [DESC_W-1:0] bd_rdata,
   input  logic              buf_we,
   input  logic [BUF_AW-1:0] buf_addr,
   input  logic [7:0]        buf_wdata,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [7:0]        tx_data,
   output logic              tx_last,
   input  logic              fr_sent,
   output logic              tx_abort,
   output logic              irq
);
   initial begin
      assert (NUM_BD >= 2) else $error("NUM_BD must be at least 2");
      assert (BUF_DEPTH == (1 << BUF_AW)) else $error("BUF_DEPTH must be a power of two");
      assert (LEN_W >= BUF_AW) else $error("LEN_W must cover the buffer address");
   end

   logic [DESC_W-1:0] seq_desc;
   logic [IDX_W-1:0]  cur_idx, wb_idx;
   logic              wb_en, wb_sent;
   logic [NUM_BD-1:0] rdy_vec;
   logic [BUF_AW-1:0] buf_raddr;

   tx_bd_table #(.NUM_BD(NUM_BD), .IDX_W(IDX_W), .DESC_W(DESC_W), .FLAG_LSB(FLAG_LSB)) u_table (
      .clk(clk), .rst_n(rst_n),
      .host_we(bd_we), .host_idx(bd_addr), .host_wdata(bd_wdata), .host_rdata(bd_rdata),
      .seq_idx(cur_idx), .seq_rdata(seq_desc),
      .wb_en(wb_en), .wb_idx(wb_idx), .wb_sent(wb_sent), .rdy_vec(rdy_vec)
   );

   tx_buf_mem #(.DEPTH(BUF_DEPTH), .AW(BUF_AW)) u_buf (
      .clk(clk), .we(buf_we), .waddr(buf_addr), .wdata(buf_wdata),
      .raddr(buf_raddr), .rdata(tx_data)
   );

   tx_bd_fsm #(.NUM_BD(NUM_BD), .IDX_W(IDX_W), .LEN_W(LEN_W), .BUF_AW(BUF_AW),
               .DESC_W(DESC_W), .FLAG_LSB(FLAG_LSB)) u_fsm (
      .clk(clk), .rst_n(rst_n), .en(en), .stop_req(stop_req), .restart_req(restart_req),
      .desc(seq_desc), .tx_ready(tx_ready), .fr_sent(fr_sent),
      .cur_idx(cur_idx), .buf_raddr(buf_raddr), .tx_valid(tx_valid), .tx_last(tx_last),
      .tx_abort(tx_abort), .irq(irq), .wb_en(wb_en), .wb_idx(wb_idx), .wb_sent(wb_sent)
   );

   // R2
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready && en && !stop_req) |=> (tx_valid && $stable(tx_data)));
   // R5
   irq_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !rdy_vec[$past(cur_idx)]);
   // R7
   stop_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && stop_req && en) |=> rdy_vec[$past(cur_idx)]);
endmodule

// File: tb/tb_tx_bd_seq.sv
`timescale 1ns/1ps
module tb_tx_bd_seq;
   localparam int NB = 8, LW = 16, BD = 256, IW = 3, AW = 8, FL = 24, DW = 29;

   logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, stop_req = 1'b0, restart_req = 1'b0;
   logic bd_we = 1'b0, buf_we = 1'b0, tx_ready, fr_sent;
   logic [IW-1:0] bd_addr = '0;
   logic [DW-1:0] bd_wdata = '0, bd_rdata;
   logic [AW-1:0] buf_addr = '0;
   logic [7:0] buf_wdata = '0, tx_data;
   logic tx_valid, tx_last, tx_abort, irq;

   always #2.5 clk = ~clk;

   tx_bd_seq dut (
      .clk(clk), .rst_n(rst_n), .en(en), .stop_req(stop_req), .restart_req(restart_req),
      .bd_we(bd_we), .bd_addr(bd_addr), .bd_wdata(bd_wdata), .bd_rdata(bd_rdata),
      .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
      .fr_sent(fr_sent), .tx_abort(tx_abort), .irq(irq)
   );

   int checks = 0, fails = 0, cyc = 0, fl_cnt = 0;
   int rx_n = 0, irq_n = 0, abort_n = 0, exp_n = 0;
   bit wd_fired = 1'b0;
   logic [7:0] bmem [BD];
   logic [7:0] rx_d [2048];
   logic       rx_l [2048];
   logic [7:0] exp_d [2048];
   logic       exp_l [2048];
   int  c_len [NB], c_base [NB];
   bit  c_last [NB], c_intr [NB], c_wrap [NB], c_sent [NB];

   function automatic logic [DW-1:0] mkd(input bit rdy, last, intr, wrap, sent,
                                         input int len, input int base);
      return {sent, wrap, intr, last, rdy, AW'(base), LW'(len)};
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic wr_bd(input int i, input logic [DW-1:0] v);
      bd_addr = IW'(i); bd_wdata = v; bd_we = 1'b1;
      tick();
      bd_we = 1'b0;
   endtask

   task automatic rd_bd(input int i, output logic [DW-1:0] v);
      bd_addr = IW'(i); #0.5;
      v = bd_rdata;
   endtask

   task automatic wait_clear(input int i, input string req);
      logic [DW-1:0] v;
      int n = 0;
      rd_bd(i, v);
      while (v[FL] && n < 2000) begin
         tick(); n++;
         rd_bd(i, v);
      end
      chk(!v[FL], req, v[FL], 0);
   endtask

   // Write entries from chain arrays and append their expected bytes.
   task automatic load_chain(input int first, input int cnt);
      for (int k = first; k < first + cnt; k++) begin
         wr_bd(k, mkd(1'b1, c_last[k], c_intr[k], c_wrap[k], c_sent[k], c_len[k], c_base[k]));
         for (int j = 0; j < c_len[k]; j++) begin
            exp_d[exp_n] = bmem[(c_base[k] + j) % BD];
            exp_l[exp_n] = c_last[k] && (j == c_len[k] - 1);
            exp_n++;
         end
      end
   endtask

   task automatic cmp_stream(input string req);
      int bad = 0, first = -1;
      chk(rx_n == exp_n, req, rx_n, exp_n);
      for (int i = 0; i < exp_n && i < rx_n; i++) begin
         if (rx_d[i] !== exp_d[i] || rx_l[i] !== exp_l[i]) begin
            bad++;
            if (first < 0) first = i;
         end
      end
      chk(bad == 0, req, (first < 0) ? 0 : rx_d[first], (first < 0) ? 0 : exp_d[first]);
   endtask

   task automatic check_back(input int first, input int cnt, input string req);
      logic [DW-1:0] v;
      for (int k = first; k < first + cnt; k++) begin
         rd_bd(k, v);
         chk(v === mkd(1'b0, c_last[k], c_intr[k], c_wrap[k], c_sent[k] | c_last[k],
                       c_len[k], c_base[k]), req, v,
             mkd(1'b0, c_last[k], c_intr[k], c_wrap[k], c_sent[k] | c_last[k], c_len[k], c_base[k]));
      end
   endtask

   task automatic reset_rx();
      rx_n = 0; exp_n = 0;
   endtask

   // Framer model and output monitor.
   initial begin
      tx_ready = 1'b0; fr_sent = 1'b0;
      forever begin
         @(posedge clk);
         cyc++;
         #1;
         fr_sent = (fl_cnt == 1);
         if (fl_cnt > 0) fl_cnt--;
         tx_ready = ($urandom % 4) != 0;
         #1;
         if (tx_valid && tx_ready) begin
            if (rx_n < 2048) begin
               rx_d[rx_n] = tx_data;
               rx_l[rx_n] = tx_last;
            end
            rx_n++;
            if (tx_last) fl_cnt = 3;
         end
         if (irq) irq_n++;
         if (tx_abort) abort_n++;
         if (cyc > 150000 && !wd_fired) begin
            wd_fired = 1'b1;
            checks++; fails++;
            $display("FAIL R1 watchdog actual=%0d expected=150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
         end
      end
   end

   initial begin
      logic [DW-1:0] v;
      int irq0, ab0, exp_irq, n0;
      void'($urandom(32'h1F2E3D4C));
      for (int a = 0; a < BD; a++) bmem[a] = 8'($urandom);
      #12; rst_n = 1'b1;
      tick();
      for (int a = 0; a < BD; a++) begin
         buf_addr = AW'(a); buf_wdata = bmem[a]; buf_we = 1'b1;
         tick();
      end
      buf_we = 1'b0;

      // R1: reset state, then polling entry 0 with nothing ready.
      rd_bd(0, v);
      chk(v == '0 && !tx_valid && !irq, "R1", v, 0);
      en = 1'b1;
      repeat (20) tick();
      chk(rx_n == 0, "R1", rx_n, 0);

      // Directed chain: mixed multi-buffer frames and zero-length entries.
      en = 1'b0; tick();
      reset_rx();
      c_len  = '{5, 3, 4, 0, 6, 2, 0, 1};
      c_last = '{0, 1, 1, 0, 0, 1, 1, 1};
      c_intr = '{1, 0, 1, 0, 1, 0, 1, 0};
      c_sent = '{0, 0, 0, 0, 1, 0, 0, 0};
      c_wrap = '{0, 0, 0, 0, 0, 0, 0, 0};
      c_base = '{10, 200, 254, 7, 30, 99, 0, 128};
      load_chain(0, NB);
      irq0 = irq_n;
      en = 1'b1;
      wait_clear(7, "R6");
      repeat (4) tick();
      cmp_stream("R2");
      chk(irq_n - irq0 == 4, "R5", irq_n - irq0, 4);
      n0 = 0;
      for (int i = 0; i < rx_n && i < 2048; i++) n0 += rx_l[i];
      chk(n0 == 4, "R3", n0, 4);
      check_back(0, NB, "R11");
      rd_bd(4, v);
      chk(v[FL+4] == 1'b1, "R4", v[FL+4], 1);
      rd_bd(6, v);
      chk(v[FL+4] == 1'b1, "R9", v[FL+4], 1);

      // R6: table end went back to 0; wrap flag on entry 0 keeps it there.
      reset_rx();
      wr_bd(1, mkd(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2, 50));
      wr_bd(0, mkd(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2, 60));
      wait_clear(0, "R6");
      repeat (30) tick();
      chk(rx_n == 2 && rx_d[0] == bmem[60], "R6", rx_n, 2);
      rd_bd(1, v);
      chk(v[FL] == 1'b1, "R6", v[FL], 1);
      wr_bd(1, '0);

      // R7 / R8: stop in the middle of a long buffer, then restart.
      reset_rx();
      c_len[0] = 40; c_base[0] = 70; c_last[0] = 1; c_intr[0] = 1; c_wrap[0] = 0; c_sent[0] = 0;
      ab0 = abort_n; irq0 = irq_n;
      load_chain(0, 1);
      n0 = 0;
      while (rx_n < 5 && n0 < 500) begin tick(); n0++; end
      stop_req = 1'b1; tick(); stop_req = 1'b0;
      tick(); #1;
      chk(!tx_valid, "R7", tx_valid, 0);
      chk(abort_n - ab0 == 1, "R7", abort_n - ab0, 1);
      rd_bd(0, v);
      chk(v[FL] == 1'b1 && v[FL+4] == 1'b0, "R7", v[FL+4:FL], 5'b00111);
      n0 = rx_n;
      repeat (10) tick();
      chk(rx_n == n0 && irq_n == irq0, "R7", rx_n, n0);
      rx_n = 0;
      restart_req = 1'b1; tick(); restart_req = 1'b0;
      wait_clear(0, "R8");
      repeat (3) tick();
      cmp_stream("R8");
      chk(irq_n - irq0 == 1, "R5", irq_n - irq0, 1);

      // R10: sequencer now sits at entry 1; re-enable goes back to entry 0.
      reset_rx();
      c_len[0] = 3; c_base[0] = 255; c_intr[0] = 0;
      load_chain(0, 1);
      repeat (20) tick();
      chk(rx_n == 0, "R10", rx_n, 0);
      en = 1'b0; tick(); #1;
      chk(!tx_valid, "R10", tx_valid, 0);
      en = 1'b1;
      wait_clear(0, "R10");
      repeat (3) tick();
      cmp_stream("R10");

      // Random chains.
      for (int r = 0; r < 4; r++) begin
         en = 1'b0; tick();
         reset_rx();
         exp_irq = 0;
         for (int k = 0; k < NB; k++) begin
            c_len[k]  = $urandom % 13;
            c_base[k] = $urandom % BD;
            c_last[k] = (k == NB - 1) || (($urandom % 3) == 0);
            c_intr[k] = $urandom % 2;
            c_wrap[k] = 0;
            c_sent[k] = 0;
            exp_irq += c_intr[k];
         end
         load_chain(0, NB);
         irq0 = irq_n;
         en = 1'b1;
         wait_clear(NB - 1, "R6");
         repeat (4) tick();
         cmp_stream("R2");
         chk(irq_n - irq0 == exp_irq, "R5", irq_n - irq0, exp_irq);
         check_back(0, NB, "R4");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule